// File: doc/BRIEF.md
# Almost-Flag Threshold Loader

This block holds the four threshold values used by the almost-empty and almost-full comparators of a dual-FIFO buffer. There are two almost-empty thresholds, one for each FIFO, and two almost-full thresholds, one for each FIFO. Pins sampled during master reset pick one of three ways to fill them:
- **Preset:** one fixed value (8, 16 or 64) goes into all four registers.
- **Parallel:** the first four wide-port writes after reset are captured.
- **Serial:** a bit stream arrives on a data pin, gated by an active-low enable.

While a parallel load is pending, the block raises a divert signal. This tells the surrounding FIFO to steer wide-port writes away from its RAM. The block also raises a programming-done signal, which the FIFO uses to hold its input-ready flag low until all four thresholds are valid.

A partial reset leaves the thresholds, the chosen method and the done state as they are. A master reset chooses the method again and either reloads the registers or clears them.

Top module: `ofs_prog_unit`

## Requirements
- R1: While `mrst_n` is low with `spm_sel`=1, `fsel`=2'b11 loads 64, `fsel`=2'b10 loads 16 and `fsel`=2'b01 loads 8 into all four thresholds. `prog_done` is 1 after the first clock edge at which `mrst_n` is high.
- R2: While `mrst_n` is low, `prog_done` and `wr_divert` are 0. `prog_done` falls only under master reset. In the parallel, serial and reserved methods, the thresholds reset to zero.
- R3: The parallel method is `spm_sel`=1 with `fsel`=2'b00. The first four `wr_stb` cycles after reset load, in this order, almost-full FIFO1, almost-empty FIFO1, almost-full FIFO2 and almost-empty FIFO2. `wr_divert` is 1 until the fourth write.
- R4: `prog_done` becomes 1 at the clock edge that captures the fourth parallel write or the 32nd serial bit, and not before.
- R5: The serial method is `spm_sel`=0 with `fsel`=2'b10. On each edge where `ser_en_n`=0, one bit is captured from `ser_dat`. The 32 bits arrive MSB first and fill almost-full FIFO1, almost-empty FIFO1, almost-full FIFO2 and almost-empty FIFO2, in that order. Edges with `ser_en_n`=1 are ignored.
- R6: Once `prog_done` is 1, `wr_stb` and serial bits leave all four thresholds unchanged, and `wr_divert` is 0.
- R7: While `prst_n` is low, the thresholds, the chosen method and `prog_done` are held, and strobes and serial bits are ignored. A parallel load that was in progress resumes at the slot where it stopped.
- R8: With `spm_sel`=0 and `fsel` other than 2'b10, the thresholds stay zero and `prog_done` stays 0 whatever the strobes do.
- R9: Each threshold is log2(`DEPTH`) bits wide, which is 8 bits by default. A parallel load takes `wr_data` bits 7..0 and ignores every higher bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low, synchronous; method pins are sampled while low |
| prst_n | input | 1 | Partial reset, active low; holds all state |
| spm_sel | input | 1 | Method group select (1: preset/parallel, 0: serial) |
| fsel | input | 2 | Threshold select pair |
| wr_data | input | DATA_W (36) | Wide-port write data |
| wr_stb | input | 1 | Wide-port write strobe |
| ser_dat | input | 1 | Serial threshold data |
| ser_en_n | input | 1 | Serial enable, active low |
| af_thr_f1 | output | OFS_W (8) | Almost-full threshold, FIFO1 |
| ae_thr_f1 | output | OFS_W (8) | Almost-empty threshold, FIFO1 |
| af_thr_f2 | output | OFS_W (8) | Almost-full threshold, FIFO2 |
| ae_thr_f2 | output | OFS_W (8) | Almost-empty threshold, FIFO2 |
| wr_divert | output | 1 | Steer wide-port writes into the thresholds instead of RAM |
| prog_done | output | 1 | All thresholds valid; gates input-ready |

## Verification
The properties watch the following on every cycle:
- `prog_done` never drops outside master reset.
- The thresholds stay frozen once programming is done and during a partial reset.
- Done only rises after a write, a serial bit or the release of a preset reset.
- A preset method raises done on the first edge after release.

Other behaviour needs the bench's scenarios:
- The slot order of parallel writes and the MSB-first serial bit order.
- That the high data bits are ignored.
- That the reserved codes never finish.
- That a load interrupted by a partial reset resumes at the right slot.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;

   localparam int NUM_THR = 4;

   typedef enum logic [2:0] {
      OM_RSVD  = 3'd0,
      OM_PRE_A = 3'd1,
      OM_PRE_B = 3'd2,
      OM_PRE_C = 3'd3,
      OM_PAR   = 3'd4,
      OM_SER   = 3'd5
   } ofs_mode_e;

   // Method decode from the pins sampled during master reset
   function automatic ofs_mode_e decode_mode(input logic spm, input logic [1:0] fs);
      ofs_mode_e m;
      case ({spm, fs})
         3'b111:  m = OM_PRE_C;
         3'b110:  m = OM_PRE_B;
         3'b101:  m = OM_PRE_A;
         3'b100:  m = OM_PAR;
         3'b010:  m = OM_SER;
         default: m = OM_RSVD;
      endcase
      return m;
   endfunction

   function automatic logic is_preset(input ofs_mode_e m);
      return (m == OM_PRE_A) || (m == OM_PRE_B) || (m == OM_PRE_C);
   endfunction

endpackage

// File: rtl/ofs_mode_latch.sv
module ofs_mode_latch
   import ofs_prog_pkg::*;
(
   input  logic            clk,
   input  logic            mrst_n,
   input  logic            spm_sel,
   input  logic [1:0]      fsel,
   output ofs_mode_e       mode_o
);

   ofs_mode_e mode_q;

   // Tracks the pins on every edge while master reset is held;
   // the value at the last reset edge is kept afterwards.
   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         mode_q <= decode_mode(spm_sel, fsel);
      end
   end

   assign mode_o = mode_q;

endmodule

// File: rtl/ofs_par_seq.sv
module ofs_par_seq #(
   parameter int NUM_SLOTS = 4,
   parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
   input  logic             clk,
   input  logic             mrst_n,
   input  logic             hold,
   input  logic             active,
   input  logic             wr_stb,
   output logic             load_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             last_o
);

   logic [IDX_W-1:0] slot_q;

   assign load_o = active && wr_stb && !hold;
   assign idx_o  = slot_q;
   assign last_o = load_o && (slot_q == IDX_W'(NUM_SLOTS - 1));

   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         slot_q <= '0;
      end else if (load_o) begin
         slot_q <= slot_q + 1'b1;
      end
   end

endmodule

// File: rtl/ofs_ser_seq.sv
module ofs_ser_seq #(
   parameter int TOTAL_BITS = 32,
   parameter int CNT_W      = $clog2(TOTAL_BITS + 1)
) (
   input  logic clk,
   input  logic mrst_n,
   input  logic hold,
   input  logic active,
   input  logic ser_en_n,
   output logic shift_o,
   output logic last_o
);

   logic [CNT_W-1:0] bits_q;

   assign shift_o = active && !ser_en_n && !hold;
   assign last_o  = shift_o && (bits_q == CNT_W'(TOTAL_BITS - 1));

   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         bits_q <= '0;
      end else if (shift_o) begin
         bits_q <= bits_q + 1'b1;
      end
   end

endmodule

// File: rtl/ofs_prog_unit.sv
module ofs_prog_unit
   import ofs_prog_pkg::*;
#(
   parameter int DEPTH    = 256,
   parameter int DATA_W   = 36,
   parameter int PRESET_A = 8,
   parameter int PRESET_B = 16,
   parameter int PRESET_C = 64,
   parameter int OFS_W    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  logic              spm_sel,
   input  logic [1:0]        fsel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_stb,
   input  logic              ser_dat,
   input  logic              ser_en_n,
   output logic [OFS_W-1:0]  af_thr_f1,
   output logic [OFS_W-1:0]  ae_thr_f1,
   output logic [OFS_W-1:0]  af_thr_f2,
   output logic [OFS_W-1:0]  ae_thr_f2,
   output logic              wr_divert,
   output logic              prog_done
);

   localparam int IDX_W     = $clog2(NUM_THR);
   localparam int SER_BITS  = NUM_THR * OFS_W;
   localparam int SER_CNT_W = $clog2(SER_BITS + 1);

   // Elaboration-time parameter checks
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_chk_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (DATA_W < OFS_W) begin : g_chk_width
      $error("DATA_W must cover one threshold");
   end
   if (PRESET_A < 1 || PRESET_C >= DEPTH || PRESET_A > PRESET_B || PRESET_B > PRESET_C) begin : g_chk_preset
      $error("preset thresholds must ascend and fit below DEPTH");
   end

   ofs_mode_e                      mode_q;
   ofs_mode_e                      mode_in;
   logic                           done_q;
   logic                           hold;
   logic                           par_active;
   logic                           ser_active;
   logic                           par_load;
   logic [IDX_W-1:0]               par_idx;
   logic                           par_last;
   logic                           ser_shift;
   logic                           ser_last;
   logic                           mode_is_pre;
   logic [OFS_W-1:0]               rst_val;
   logic [NUM_THR-1:0][OFS_W-1:0]  thr_w;

   assign mode_in     = decode_mode(spm_sel, fsel);
   assign hold        = !prst_n;
   assign par_active  = (mode_q == OM_PAR) && !done_q;
   assign ser_active  = (mode_q == OM_SER) && !done_q;
   assign mode_is_pre = is_preset(mode_q);

   always_comb begin
      case (mode_in)
         OM_PRE_A: rst_val = OFS_W'(PRESET_A);
         OM_PRE_B: rst_val = OFS_W'(PRESET_B);
         OM_PRE_C: rst_val = OFS_W'(PRESET_C);
         default:  rst_val = '0;
      endcase
   end

   ofs_mode_latch u_mode (
      .clk     (clk),
      .mrst_n  (mrst_n),
      .spm_sel (spm_sel),
      .fsel    (fsel),
      .mode_o  (mode_q)
   );

   ofs_par_seq #(.NUM_SLOTS(NUM_THR), .IDX_W(IDX_W)) u_par (
      .clk    (clk),
      .mrst_n (mrst_n),
      .hold   (hold),
      .active (par_active),
      .wr_stb (wr_stb),
      .load_o (par_load),
      .idx_o  (par_idx),
      .last_o (par_last)
   );

   ofs_ser_seq #(.TOTAL_BITS(SER_BITS), .CNT_W(SER_CNT_W)) u_ser (
      .clk      (clk),
      .mrst_n   (mrst_n),
      .hold     (hold),
      .active   (ser_active),
      .ser_en_n (ser_en_n),
      .shift_o  (ser_shift),
      .last_o   (ser_last)
   );

   // Slot 0 is loaded first; serial bits enter at the last slot and move
   // toward slot 0, so the first bit ends as the MSB of slot 0.
   for (genvar gi = 0; gi < NUM_THR; gi++) begin : g_thr
      logic [OFS_W-1:0] q;
      logic             carry_in;

      if (gi == NUM_THR - 1) begin : g_tail
         assign carry_in = ser_dat;
      end else begin : g_link
         assign carry_in = thr_w[gi + 1][OFS_W-1];
      end

      always_ff @(posedge clk) begin
         if (!mrst_n) begin
            q <= rst_val;
         end else if (par_load && (par_idx == IDX_W'(gi))) begin
            q <= wr_data[OFS_W-1:0];
         end else if (ser_shift) begin
            if (OFS_W > 1) begin
               q <= {q[OFS_W-2:0], carry_in};
            end else begin
               q <= carry_in;
            end
         end
      end

      assign thr_w[gi] = q;
   end

   if (DATA_W > OFS_W) begin : g_unused_hi
      logic unused_hi;
      assign unused_hi = ^wr_data[DATA_W-1:OFS_W];
   end

   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         done_q <= 1'b0;
      end else if (!hold) begin
         if (mode_is_pre || par_last || ser_last) begin
            done_q <= 1'b1;
         end
      end
   end

   assign af_thr_f1 = thr_w[0];
   assign ae_thr_f1 = thr_w[1];
   assign af_thr_f2 = thr_w[2];
   assign ae_thr_f2 = thr_w[3];
   assign wr_divert = mrst_n && par_active;
   assign prog_done = done_q;

endmodule

// File: rtl/ofs_prog_chk.sv
module ofs_prog_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         mrst_n,
   input logic         prst_n,
   input logic         wr_stb,
   input logic         ser_en_n,
   input logic         prog_done,
   input logic         mode_pre,
   input logic [W-1:0] thr_all
);

   // R2
   done_only_falls_in_reset_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      $fell(prog_done) |-> !$past(mrst_n));

   // R6
   frozen_after_done_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      ($past(prog_done) && $past(mrst_n)) |-> $stable(thr_all));

   // R7
   frozen_in_partial_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      (!$past(prst_n) && $past(mrst_n)) |-> $stable(thr_all));

   // R4
   done_has_cause_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      $rose(prog_done) |-> ($past(wr_stb) || !$past(ser_en_n) || $past(mode_pre)));

   // R1
   preset_done_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      (mrst_n && !$past(mrst_n) && prst_n && mode_pre) |=> prog_done);

endmodule

bind ofs_prog_unit ofs_prog_chk #(.W(4 * OFS_W)) chk_i (
   .clk       (clk),
   .mrst_n    (mrst_n),
   .prst_n    (prst_n),
   .wr_stb    (wr_stb),
   .ser_en_n  (ser_en_n),
   .prog_done (prog_done),
   .mode_pre  (mode_is_pre),
   .thr_all   ({af_thr_f1, ae_thr_f1, af_thr_f2, ae_thr_f2})
);

// File: tb/ofs_prog_unit_tb_top.sv
module ofs_prog_unit_tb_top;

   localparam int CLK_P  = 10;
   localparam int DATA_W = 36;
   localparam int OFS_W  = 8;

   typedef struct {
      int          sel;
      logic [35:0] expv;
      string       req;
   } exp_t;

   logic              clk = 1'b0;
   logic              mrst_n = 1'b0;
   logic              prst_n = 1'b1;
   logic              spm_sel = 1'b1;
   logic [1:0]        fsel = 2'b11;
   logic [DATA_W-1:0] wr_data = '0;
   logic              wr_stb = 1'b0;
   logic              ser_dat = 1'b0;
   logic              ser_en_n = 1'b1;
   logic [OFS_W-1:0]  af_thr_f1, ae_thr_f1, af_thr_f2, ae_thr_f2;
   logic              wr_divert, prog_done;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   ofs_prog_unit dut_i (
      .clk       (clk),
      .mrst_n    (mrst_n),
      .prst_n    (prst_n),
      .spm_sel   (spm_sel),
      .fsel      (fsel),
      .wr_data   (wr_data),
      .wr_stb    (wr_stb),
      .ser_dat   (ser_dat),
      .ser_en_n  (ser_en_n),
      .af_thr_f1 (af_thr_f1),
      .ae_thr_f1 (ae_thr_f1),
      .af_thr_f2 (af_thr_f2),
      .ae_thr_f2 (ae_thr_f2),
      .wr_divert (wr_divert),
      .prog_done (prog_done)
   );

   function automatic logic [35:0] pick(input int sel);
      case (sel)
         0: return 36'(af_thr_f1);
         1: return 36'(ae_thr_f1);
         2: return 36'(af_thr_f2);
         3: return 36'(ae_thr_f2);
         4: return 36'(prog_done);
         default: return 36'(wr_divert);
      endcase
   endfunction

   // Monitor: compares queued expectations shortly after each rising edge
   always begin
      @(posedge clk);
      #2;
      while (exp_q.size() > 0) begin
         exp_t e;
         logic [35:0] act;
         e = exp_q.pop_front();
         act = pick(e.sel);
         n_chk++;
         if (act !== e.expv) begin
            n_fail++;
            $display("FAIL %s output %0d: actual %0h expected %0h", e.req, e.sel, act, e.expv);
         end
      end
   end

   task automatic push(input int sel, input logic [35:0] v, input string req);
      exp_t e;
      e.sel = sel; e.expv = v; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic exp_all(input logic [7:0] y1, input logic [7:0] x1, input logic [7:0] y2,
                          input logic [7:0] x2, input logic dn, input logic dv, input string req);
      push(0, 36'(y1), req);
      push(1, 36'(x1), req);
      push(2, 36'(y2), req);
      push(3, 36'(x2), req);
      push(4, 36'(dn), req);
      push(5, 36'(dv), req);
   endtask

   task automatic settle();
      @(posedge clk);
      #1;
   endtask

   // Hold master reset with the given pins, then release it
   task automatic mreset(input logic spm, input logic [1:0] fs, input logic [7:0] rv, input string req);
      @(negedge clk);
      mrst_n = 1'b0; spm_sel = spm; fsel = fs; wr_stb = 1'b0; ser_en_n = 1'b1;
      repeat (4) @(posedge clk);
      #1;
      exp_all(rv, rv, rv, rv, 1'b0, 1'b0, req);
      @(negedge clk);
      mrst_n = 1'b1;
      settle();
   endtask

   task automatic par_write(input logic [DATA_W-1:0] d);
      @(negedge clk);
      wr_stb = 1'b1; wr_data = d;
      settle();
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic ser_bit(input logic b);
      @(negedge clk);
      ser_en_n = 1'b0; ser_dat = b;
      @(negedge clk);
      ser_en_n = 1'b1;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] sword;

      // R1: preset 64, done one edge after release
      mreset(1'b1, 2'b11, 8'd64, "R1_R2 reset state preset64");
      exp_all(8'd64, 8'd64, 8'd64, 8'd64, 1'b1, 1'b0, "R1 preset64 done");
      // R6: writes after done are ignored
      par_write(36'hF_FFFF_FF11);
      exp_all(8'd64, 8'd64, 8'd64, 8'd64, 1'b1, 1'b0, "R6 write after preset");

      mreset(1'b1, 2'b10, 8'd16, "R1 preset16 in reset");
      exp_all(8'd16, 8'd16, 8'd16, 8'd16, 1'b1, 1'b0, "R1 preset16 done");
      mreset(1'b1, 2'b01, 8'd8, "R1 preset8 in reset");
      exp_all(8'd8, 8'd8, 8'd8, 8'd8, 1'b1, 1'b0, "R1 preset8 done");

      // R3/R4/R7/R9: parallel method, slot order, upper bits dropped
      mreset(1'b1, 2'b00, 8'd0, "R2 parallel reset clears");
      exp_all(8'd0, 8'd0, 8'd0, 8'd0, 1'b0, 1'b1, "R3 divert pending");
      par_write(36'hA_BCDE_F31F);
      par_write(36'h5_5555_5505);
      exp_all(8'h1F, 8'h05, 8'd0, 8'd0, 1'b0, 1'b1, "R3_R9 first two slots");
      // R7: strobes during partial reset are ignored and progress is kept
      @(negedge clk);
      prst_n = 1'b0; wr_stb = 1'b1; wr_data = 36'h0_0000_00AA;
      repeat (3) @(posedge clk);
      #1;
      exp_all(8'h1F, 8'h05, 8'd0, 8'd0, 1'b0, 1'b1, "R7 partial mid-load");
      @(negedge clk);
      prst_n = 1'b1; wr_stb = 1'b0;
      par_write(36'hF_0000_00FC);
      exp_all(8'h1F, 8'h05, 8'hFC, 8'd0, 1'b0, 1'b1, "R4 not done after three");
      par_write(36'h8_0000_0101);
      exp_all(8'h1F, 8'h05, 8'hFC, 8'h01, 1'b1, 1'b0, "R3_R4 fourth write done");
      par_write(36'h0_0000_0077);
      exp_all(8'h1F, 8'h05, 8'hFC, 8'h01, 1'b1, 1'b0, "R6 extra write ignored");
      @(negedge clk);
      prst_n = 1'b0; ser_en_n = 1'b0; wr_stb = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      exp_all(8'h1F, 8'h05, 8'hFC, 8'h01, 1'b1, 1'b0, "R7 partial keeps done");
      @(negedge clk);
      prst_n = 1'b1; ser_en_n = 1'b1; wr_stb = 1'b0;
      settle();
      exp_all(8'h1F, 8'h05, 8'hFC, 8'h01, 1'b1, 1'b0, "R7 after partial");

      // R5: serial method, MSB first, gaps between bits
      mreset(1'b0, 2'b10, 8'd0, "R2 serial reset clears");
      sword = {8'hC3, 8'h10, 8'h7E, 8'h02};
      for (int i = 31; i >= 1; i--) ser_bit(sword[i]);
      settle();
      push(4, 36'd0, "R4 serial not done at 31");
      ser_bit(sword[0]);
      settle();
      exp_all(8'hC3, 8'h10, 8'h7E, 8'h02, 1'b1, 1'b0, "R5_R4 serial load");
      for (int i = 0; i < 8; i++) ser_bit(1'b1);
      settle();
      exp_all(8'hC3, 8'h10, 8'h7E, 8'h02, 1'b1, 1'b0, "R6 extra serial bits");

      // R8: reserved method never completes
      mreset(1'b0, 2'b00, 8'd0, "R8 reserved reset");
      par_write(36'h0_0000_0033);
      for (int i = 0; i < 40; i++) ser_bit(1'b1);
      settle();
      exp_all(8'd0, 8'd0, 8'd0, 8'd0, 1'b0, 1'b0, "R8 reserved idle");
      mreset(1'b0, 2'b11, 8'd0, "R8 reserved code 11");
      repeat (5) settle();
      exp_all(8'd0, 8'd0, 8'd0, 8'd0, 1'b0, 1'b0, "R8 reserved 11 idle");

      // R1: master reset re-selects a preset after another method
      mreset(1'b1, 2'b01, 8'd8, "R1 reselect preset8");
      exp_all(8'd8, 8'd8, 8'd8, 8'd8, 1'b1, 1'b0, "R1 reselect done");

      repeat (3) settle();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule